// File: doc/BRIEF.md
# Three-Wire Serial Memory Master

This controller sits on the host side of a three-wire serial memory link. It drives the chip-select, serial clock and serial data-in lines, and it samples the memory's serial data-out line. A request port with a valid/ready handshake takes a read or a write, a word address and, for writes, a data word. The controller builds the serial frame and returns a single-cycle completion pulse. For a read, the completion pulse comes with the fetched word.

The serial clock comes from the system clock: each of its high and low phases lasts a parameterised number of system cycles. The controller changes data-in while the serial clock is low, so the memory latches a settled value on every rising edge. Data-out is sampled at the end of each low phase. On a read, the memory sends one padding zero before the real word, and the controller drops it.

A write does not finish when its last bit has been sent. The controller first drops chip-select for a fixed number of cycles, which starts the internal programming. It then raises chip-select again and watches data-out until the memory signals ready. If ready does not appear within a bounded number of cycles, the controller gives up and flags an error together with the completion pulse.

Top module: `uwire_mem_master`

## Requirements
- R1: Every frame opens with a 1 start bit, then a two-bit opcode, then ADDR_W address bits, MSB first. The opcode is 2'b10 for a read and 2'b01 for a write, sent high bit first.
- R2: `di` changes only while `sk` is low; it holds its value for every cycle that `sk` is high.
- R3: While `cs` is high in a frame, each `sk` high phase and each low phase lasts DIV system cycles. `sk` is never high while `cs` is low.
- R4: A read clocks DATA_W+1 bits in after the address and drops the first one (the padding zero). `rdata` then holds the remaining DATA_W bits, first received in the MSB, and is valid while `done` is high.
- R5: A write sends DATA_W data bits, MSB first, directly after the address.
- R6: After the last data bit of a write, `cs` stays low for exactly GAP_CYC cycles and then returns high.
- R7: During the post-write poll, `cs` stays high until `do_in` reads 1. Then `done` pulses with `err` low.
- R8: If `do_in` stays 0 for POLL_MAX poll cycles, polling stops and `done` pulses with `err` high. `err` is never high without `done`.
- R9: `req_ready` is high only when the controller is idle, and a request is taken when `req_valid` and `req_ready` are both high. `done` lasts one cycle and is followed by `req_ready` high.
- R10: After reset and after every completed operation, `cs` and `sk` are low until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout, valid with done |
| rdata | output | DATA_W | Read word, valid with done |
| cs | output | 1 | Memory chip select |
| sk | output | 1 | Serial clock |
| di | output | 1 | Serial data to memory |
| do_in | input | 1 | Serial data from memory |

## Verification
The assertions check these properties on every cycle:
- `di` holds steady across the serial-clock high phase.
- Each high phase lasts DIV cycles.
- The serial clock is low whenever chip-select is low.
- The lines are quiet while idle and at completion.
- The completion pulse lasts one cycle and is followed by ready.
- The error flag appears only with completion.

Only the bench scenarios can show the frame content against a modelled memory, the dropping of the padding bit, the exact chip-select gap after writes, the exit from polling at the ready signal, and the timeout against a memory that stays busy too long.

// File: rtl/uwire_mem_master.sv
module uwire_mem_master #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int DIV      = 2,
  parameter int GAP_CYC  = 25,
  parameter int POLL_MAX = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              cs,
  output logic              sk,
  output logic              di,
  input  logic              do_in
);
  localparam int HDR_W    = 3 + ADDR_W;
  localparam int SR_W     = HDR_W + DATA_W;
  localparam int WR_SLOTS = HDR_W + DATA_W;
  localparam int RD_SLOTS = HDR_W + DATA_W + 1;
  localparam int SLOT_W   = $clog2(RD_SLOTS + 1);
  localparam int DIV_W    = $clog2(DIV + 1);
  localparam int WMAX     = (GAP_CYC > POLL_MAX) ? GAP_CYC : POLL_MAX;
  localparam int WAIT_W   = $clog2(WMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL, S_FIN} st_t;

  st_t               st;
  logic [SR_W-1:0]   sr;
  logic [DATA_W-1:0] rx;
  logic [SLOT_W-1:0] slot;
  logic [DIV_W-1:0]  dcnt;
  logic [WAIT_W-1:0] wcnt;
  logic              phase, is_wr, to_flag;
  logic [SLOT_W-1:0] last_slot;

  assign last_slot = is_wr ? SLOT_W'(WR_SLOTS - 1) : SLOT_W'(RD_SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sr      <= '0;
      rx      <= '0;
      slot    <= '0;
      dcnt    <= '0;
      wcnt    <= '0;
      phase   <= 1'b0;
      is_wr   <= 1'b0;
      to_flag <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          sr      <= {1'b1, (req_write ? 2'b01 : 2'b10), req_addr,
                      (req_write ? req_wdata : {DATA_W{1'b0}})};
          is_wr   <= req_write;
          slot    <= '0;
          dcnt    <= '0;
          phase   <= 1'b0;
          to_flag <= 1'b0;
          st      <= S_SHIFT;
        end
        S_SHIFT: begin
          if (dcnt == DIV_W'(DIV - 1)) begin
            dcnt <= '0;
            if (!phase) begin
              phase <= 1'b1;
              if (!is_wr && slot >= SLOT_W'(HDR_W))
                rx <= {rx[DATA_W-2:0], do_in};
            end else begin
              phase <= 1'b0;
              sr    <= {sr[SR_W-2:0], 1'b0};
              if (slot == last_slot) begin
                wcnt <= '0;
                st   <= is_wr ? S_GAP : S_FIN;
              end else begin
                slot <= slot + 1'b1;
              end
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        S_GAP: begin
          if (wcnt == WAIT_W'(GAP_CYC - 1)) begin
            wcnt <= '0;
            st   <= S_POLL;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_POLL: begin
          if (do_in) begin
            st <= S_FIN;
          end else if (wcnt == WAIT_W'(POLL_MAX - 1)) begin
            to_flag <= 1'b1;
            st      <= S_FIN;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign cs        = (st == S_SHIFT) || (st == S_POLL);
  assign sk        = (st == S_SHIFT) && phase;
  assign di        = (st == S_SHIFT) && sr[SR_W-1];
  assign done      = (st == S_FIN);
  assign err       = done && to_flag;
  assign rdata     = rx;
endmodule

module uwire_mem_master_chk #(
  parameter int DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic err,
  input logic cs,
  input logic sk,
  input logic di
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else        hi_cnt <= sk ? hi_cnt + 16'd1 : 16'd0;
  end

  a_r2_di_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sk && $past(sk)) |-> $stable(di));

  a_r3_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sk |-> cs);

  a_r3_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sk) |-> (hi_cnt == 16'(DIV)));

  a_r8_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || done) |-> (!cs && !sk));
endmodule

bind uwire_mem_master uwire_mem_master_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .err(err), .cs(cs), .sk(sk), .di(di)
);

// File: tb/uwire_mem_master_test.sv
module uwire_mem_master_test;
  localparam int AW = 6, DW = 16, DIV = 2, GAP = 5, PMAX = 40;
  localparam int H = 3 + AW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done, err, cs, sk, di, do_in;
  logic [DW-1:0] rdata;

  uwire_mem_master #(.ADDR_W(AW), .DATA_W(DW), .DIV(DIV), .GAP_CYC(GAP), .POLL_MAX(PMAX)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .err(err), .rdata(rdata), .cs(cs), .sk(sk), .di(di), .do_in(do_in));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;

  // memory model
  logic [DW-1:0] dev_mem [0:(1<<AW)-1];
  logic [DW-1:0] exp_mem [0:(1<<AW)-1];
  logic [H-1:0]  hdr;
  logic [DW-1:0] wsr;
  int  bitcnt = 0, busy_cnt = 0, busy_len = 0;
  logic sk_d = 0, cs_d = 0, do_reg = 0;

  assign do_in = cs && ((bitcnt == 0) ? (busy_cnt == 0) : do_reg);

  always @(posedge clk) begin
    sk_d <= sk;
    cs_d <= cs;
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (!cs && cs_d) begin
      if (hdr[H-2:H-3] == 2'b01 && bitcnt == H + DW) begin
        dev_mem[hdr[AW-1:0]] <= wsr;
        busy_cnt <= busy_len;
      end
      bitcnt <= 0;
    end else if (cs && sk && !sk_d) begin
      if (bitcnt < H) begin
        hdr <= {hdr[H-2:0], di};
        do_reg <= 1'b0;
      end else if (hdr[H-2:H-3] == 2'b10) begin
        do_reg <= (bitcnt - H < DW) ? dev_mem[hdr[AW-1:0]][DW-1-(bitcnt-H)] : 1'b0;
      end else begin
        wsr <= {wsr[DW-2:0], di};
      end
      bitcnt <= bitcnt + 1;
    end
  end

  // line monitors
  int hi_run = 0, di_bad = 0;
  logic sk_p = 0, di_p = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sk && sk_p && di != di_p) di_bad++;
      if (sk) hi_run++;
      else if (sk_p) begin
        checks++;
        if (hi_run != DIV) begin
          errors++;
          $display("FAIL R3 sk high run %0d expected %0d", hi_run, DIV);
        end
        hi_run = 0;
      end
    end
    sk_p = sk;
    di_p = di;
  end

  task automatic finish_sim();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_sim();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [H-1:0] exp_hdr(input bit wr, input logic [AW-1:0] a);
    return {1'b1, (wr ? 2'b01 : 2'b10), a};
  endfunction

  task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int blen, input bit exp_err);
    int gap;
    busy_len = blen;
    @(negedge clk);
    chk(req_ready, "R9 ready before request", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready && cs, "R9 accepted, busy", {req_ready, cs}, 2'b01);
    if (wr) begin
      while (cs) @(negedge clk);
      gap = 0;
      while (!cs) begin gap++; @(negedge clk); end
      chk(gap == GAP, "R6 cs gap after write", gap, GAP);
    end
    while (!done) @(negedge clk);
    chk(hdr == exp_hdr(wr, a), "R1 frame header", hdr, exp_hdr(wr, a));
    chk(!cs && !sk, "R10 lines quiet at done", {cs, sk}, 0);
    if (wr) begin
      chk(err == exp_err, exp_err ? "R8 timeout err" : "R7 ready ends poll", err, exp_err);
      chk(dev_mem[a] == d, "R5 data written", dev_mem[a], d);
      exp_mem[a] = d;
    end else begin
      chk(rdata == exp_mem[a], "R4 read data without dummy", rdata, exp_mem[a]);
      chk(!err, "R8 no err on read", err, 0);
    end
    @(negedge clk);
    chk(!done && req_ready, "R9 done one cycle then ready", {done, req_ready}, 2'b01);
    while (busy_cnt != 0) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < (1 << AW); i++) begin
      dev_mem[i] = DW'(i * 16'h1357 + 16'h00a5);
      exp_mem[i] = dev_mem[i];
    end
    repeat (3) @(negedge clk);
    chk(!cs && !sk && req_ready && !done, "R10 reset state", {cs, sk, req_ready, done}, 4'b0010);
    rst_n = 1;
    @(negedge clk);
    // directed corners
    run_op(0, 6'h00, '0, 0, 0);
    run_op(0, 6'h3f, '0, 0, 0);
    run_op(1, 6'h2a, 16'hffff, 0, 0);
    run_op(0, 6'h2a, '0, 0, 0);
    run_op(1, 6'h15, 16'h0000, 12, 0);
    run_op(0, 6'h15, '0, 0, 0);
    run_op(1, 6'h01, 16'h8001, PMAX - 2, 0);
    run_op(1, 6'h02, 16'h1234, PMAX + 20, 1);
    run_op(0, 6'h02, '0, 0, 0);
    // random traffic
    for (int n = 0; n < 40; n++) begin
      automatic bit wr = $urandom_range(0, 1);
      automatic logic [AW-1:0] a = AW'($urandom_range(0, (1 << AW) - 1));
      automatic logic [DW-1:0] d = DW'($urandom);
      automatic int bl = $urandom_range(0, 30);
      run_op(wr, a, d, bl, 0);
    end
    chk(di_bad == 0, "R2 di changes while sk high", di_bad, 0);
    finish_sim();
  end
endmodule